// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns one instruction's addressing mode into an effective operand address for a 64-bit accumulator-style processor. It also works out the program counter that follows the operand bytes. A decoder pulses `start_i` with the mode code, the size selects, the current PC and the two index registers. The block then walks a byte-wide synchronous read port to collect the address field and, for the indirect modes, an 8-byte pointer. When it finishes, it pulses `done_o` and holds the effective address, the next PC and the number of cycles spent.

Address fields are assembled little-endian and zero-extended. One index register is added before the pointer read and the other after it, which gives the pre-indexed and post-indexed indirect forms. Immediate operands cost no memory traffic; only the PC step is computed. The step can be sized, forced to one byte, or suppressed for the opcodes that need it.

Top module: `op_addr_gen`

## Requirements
- R1: After reset, `done_o`, `mem_rd_o`, `addr_o`, `pc_o` and `cycles_o` are all zero.
- R2: Implied mode (mode code 0, and unused codes 9 to 15) raises `done_o` in the start cycle itself, with `addr_o` = 0, `pc_o` = `pc_i`, `cycles_o` = 0 and no memory read.
- R3: Immediate mode (code 1) reports `addr_o` = start PC and `done_o` one cycle after start, with `cycles_o` = 1 and no memory read.
- R4: In immediate mode the PC step follows `imm_fix_i`: 0 gives 1 << `imm_sz_i` bytes, 1 (and 3) gives exactly 1, and 2 gives 0, whatever `imm_sz_i` holds.
- R5: Zero-page (code 2) and absolute (code 8) modes read N = 1 << `fld_sz_i` bytes from PC, PC+1, … and assemble them least significant byte first, with the upper bytes zero. The value is the address, `pc_o` = PC + N, and `cycles_o` = N + 2.
- R6: Reads are issued one byte address per cycle at consecutive addresses within each fetch. Data is taken the cycle after issue. `mem_rd_o` is only high while the block is busy. The read count is N for the direct modes and N + 8 for the pointer modes.
- R7: Zero-page X (code 3) adds X, and zero-page Y (code 4) adds Y, to the assembled field. `cycles_o` = N + 3.
- R8: Indirect mode (code 5) reads an 8-byte little-endian pointer at the field value and returns it unchanged. `cycles_o` = N + 11.
- R9: Pre-indexed indirect mode (code 6) reads the pointer at field + X and returns it. `cycles_o` = N + 12.
- R10: Post-indexed indirect mode (code 7) reads the pointer at the field value and returns pointer + Y. `cycles_o` = N + 12.
- R11: `done_o` after a multi-cycle operation is a one-cycle pulse. `start_i` is ignored while busy and does not change the result.
- R12: Every address and PC sum wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation (accepted when idle) |
| mode_i | input | 4 | Addressing mode code |
| imm_sz_i | input | 2 | Immediate operand size select (1, 2, 4, 8 bytes) |
| imm_fix_i | input | 2 | Immediate PC-step override |
| fld_sz_i | input | 2 | Address field length select (1, 2, 4, 8 bytes) |
| pc_i | input | AW | Current program counter |
| x_i | input | AW | X index register |
| y_i | input | AW | Y index register |
| mem_addr_o | output | AW | Byte read address |
| mem_rd_o | output | 1 | Byte read request |
| mem_data_i | input | 8 | Read data, one cycle after request |
| done_o | output | 1 | Result valid strobe |
| addr_o | output | AW | Effective address |
| pc_o | output | AW | Program counter after the operand |
| cycles_o | output | CW | Cycles used, valid with `done_o` |

## Verification
The bench builds the block with the default AW = 64 and CW = 6. At that width a full 8-byte pointer and a full 8-byte address field can be fetched. An index add that runs past 2^64 can be shown to wrap. The cycle count of the slowest mode with an 8-byte field (20) fits the counter with margin. With these values, all four field lengths, every PC-step override and a start pulse injected mid-run are checked against a sparse byte memory model.

// File: rtl/op_addr_pkg.sv
package op_addr_pkg;

  localparam logic [3:0] AM_IMPL = 4'd0;
  localparam logic [3:0] AM_IMM  = 4'd1;
  localparam logic [3:0] AM_ZP   = 4'd2;
  localparam logic [3:0] AM_ZPX  = 4'd3;
  localparam logic [3:0] AM_ZPY  = 4'd4;
  localparam logic [3:0] AM_IND  = 4'd5;
  localparam logic [3:0] AM_INDX = 4'd6;
  localparam logic [3:0] AM_INDY = 4'd7;
  localparam logic [3:0] AM_ABS  = 4'd8;

  localparam logic [1:0] IMM_SIZED = 2'd0;
  localparam logic [1:0] IMM_ONE   = 2'd1;
  localparam logic [1:0] IMM_NONE  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_IDX,
    ST_DONE
  } ag_state_e;

endpackage

// File: rtl/op_addr_len.sv
module op_addr_len
  import op_addr_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic [1:0]    imm_sz_i,
  input  logic [1:0]    imm_fix_i,
  input  logic [1:0]    fld_sz_i,
  output logic [LW-1:0] imm_step_o,
  output logic [LW-1:0] fld_len_o
);

  always_comb begin
    fld_len_o = LW'(1) << fld_sz_i;
    unique case (imm_fix_i)
      IMM_SIZED: imm_step_o = LW'(1) << imm_sz_i;
      IMM_NONE:  imm_step_o = '0;
      default:   imm_step_o = LW'(1);
    endcase
  end

endmodule

// File: rtl/op_addr_fetch.sv
module op_addr_fetch #(
  parameter int AW = 64,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [7:0]    mem_data_i,
  output logic          fin_o,
  output logic [AW-1:0] val_o
);

  logic          active_q, rv_q;
  logic [AW-1:0] base_q, acc_q;
  logic [LW-1:0] len_q, iss_q, rcv_q;

  assign mem_rd_o   = active_q && (iss_q < len_q);
  assign mem_addr_o = base_q + AW'(iss_q);
  assign fin_o      = rv_q && (rcv_q == len_q - LW'(1));
  // little-endian placement of the byte arriving now
  assign val_o      = acc_q | (AW'(mem_data_i) << {rcv_q, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rv_q     <= 1'b0;
      base_q   <= '0;
      acc_q    <= '0;
      len_q    <= '0;
      iss_q    <= '0;
      rcv_q    <= '0;
    end else begin
      rv_q <= go_i ? 1'b0 : mem_rd_o;
      if (go_i) begin
        active_q <= 1'b1;
        base_q   <= base_i;
        len_q    <= len_i;
        iss_q    <= '0;
        rcv_q    <= '0;
        acc_q    <= '0;
      end else begin
        if (mem_rd_o) iss_q <= iss_q + LW'(1);
        if (rv_q) begin
          acc_q <= val_o;
          rcv_q <= rcv_q + LW'(1);
          if (fin_o) active_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/op_addr_gen.sv
module op_addr_gen
  import op_addr_pkg::*;
#(
  parameter int AW = 64,
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    imm_sz_i,
  input  logic [1:0]    imm_fix_i,
  input  logic [1:0]    fld_sz_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [7:0]    mem_data_i,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] pc_o,
  output logic [CW-1:0] cycles_o
);

  localparam int NBYTES = AW / 8;
  localparam int LW     = $clog2(NBYTES) + 1;

  ag_state_e     state_q;
  logic [3:0]    mode_q;
  logic [AW-1:0] addr_q, pc_q, pcs_q, x_q, y_q;
  logic          ptr_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] flen_q;

  logic [LW-1:0] imm_step, flen, go_len;
  logic [AW-1:0] go_base, idx_sum, fval;
  logic          go, fin, busy, impl_now, fetch_mode;

  op_addr_len #(.LW(LW)) i_len (
    .imm_sz_i   (imm_sz_i),
    .imm_fix_i  (imm_fix_i),
    .fld_sz_i   (fld_sz_i),
    .imm_step_o (imm_step),
    .fld_len_o  (flen)
  );

  op_addr_fetch #(.AW(AW), .LW(LW)) i_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .base_i     (go_base),
    .len_i      (go_len),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_data_i (mem_data_i),
    .fin_o      (fin),
    .val_o      (fval)
  );

  assign busy       = (state_q != ST_IDLE);
  assign fetch_mode = (mode_i >= AM_ZP) && (mode_i <= AM_ABS);
  assign impl_now   = !busy && start_i && !fetch_mode && (mode_i != AM_IMM);
  assign idx_sum    = addr_q + (((mode_q == AM_ZPY) || (mode_q == AM_INDY)) ? y_q : x_q);

  // fetch launches: field at start, pointer after field or after pre-index
  always_comb begin
    go      = 1'b0;
    go_base = pc_i;
    go_len  = flen;
    unique case (state_q)
      ST_IDLE: go = start_i && fetch_mode;
      ST_FETCH: begin
        if (fin && !ptr_q && ((mode_q == AM_IND) || (mode_q == AM_INDY))) begin
          go      = 1'b1;
          go_base = fval;
          go_len  = LW'(NBYTES);
        end
      end
      ST_IDX: begin
        if (mode_q == AM_INDX) begin
          go      = 1'b1;
          go_base = idx_sum;
          go_len  = LW'(NBYTES);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= AM_IMPL;
      addr_q  <= '0;
      pc_q    <= '0;
      pcs_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      ptr_q   <= 1'b0;
      cnt_q   <= '0;
      flen_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q  <= '0;
            mode_q <= mode_i;
            pcs_q  <= pc_i;
            x_q    <= x_i;
            y_q    <= y_i;
            ptr_q  <= 1'b0;
            flen_q <= flen;
            if (mode_i == AM_IMM) begin
              addr_q  <= pc_i;
              pc_q    <= pc_i + AW'(imm_step);
              state_q <= ST_DONE;
            end else if (fetch_mode) begin
              state_q <= ST_FETCH;
            end else begin
              addr_q <= '0;
              pc_q   <= pc_i;
            end
          end
        end
        ST_FETCH: begin
          cnt_q <= cnt_q + CW'(1);
          if (fin) begin
            addr_q <= fval;
            if (!ptr_q) begin
              pc_q <= pcs_q + AW'(flen_q);
              if ((mode_q == AM_ZP) || (mode_q == AM_ABS)) state_q <= ST_DONE;
              else if ((mode_q == AM_IND) || (mode_q == AM_INDY)) ptr_q <= 1'b1;
              else state_q <= ST_IDX;
            end else begin
              state_q <= (mode_q == AM_INDY) ? ST_IDX : ST_DONE;
            end
          end
        end
        ST_IDX: begin
          cnt_q  <= cnt_q + CW'(1);
          addr_q <= idx_sum;
          if (mode_q == AM_INDX) begin
            ptr_q   <= 1'b1;
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = impl_now || (state_q == ST_DONE);
  assign addr_o   = impl_now ? '0 : addr_q;
  assign pc_o     = impl_now ? pc_i : pc_q;
  assign cycles_o = (state_q == ST_DONE) ? (cnt_q + CW'(1)) : '0;

endmodule

// File: rtl/op_addr_gen_chk.sv
module op_addr_gen_chk
  import op_addr_pkg::*;
#(
  parameter int AW = 64,
  parameter int CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          done_o,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] pc_o,
  input logic [CW-1:0] cycles_o,
  input logic          busy
);

  a_r2_impl_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i && mode_i == AM_IMPL) |-> (done_o && addr_o == '0 && pc_o == pc_i && cycles_o == '0));

  a_r3_imm_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && busy && $past(start_i && !busy)) |-> (cycles_o == CW'(1)));

  a_r6_rd_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy);

  a_r6_rd_consecutive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && busy) |=> !busy);

endmodule

bind op_addr_gen op_addr_gen_chk #(.AW(AW), .CW(CW)) i_chk (.*);

// File: tb/test_op_addr_gen.sv
module test_op_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int CW = 6;

  localparam logic [3:0] M_IMPL = 4'd0, M_IMM = 4'd1, M_ZP = 4'd2, M_ZPX = 4'd3,
                         M_ZPY = 4'd4, M_IND = 4'd5, M_INDX = 4'd6, M_INDY = 4'd7,
                         M_ABS = 4'd8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [1:0]    imm_sz = '0, imm_fix = '0, fld_sz = '0;
  logic [AW-1:0] pc = '0, xr = '0, yr = '0;
  logic [AW-1:0] mem_addr, addr, pc_out;
  logic          mem_rd, done;
  logic [7:0]    rdata = '0;
  logic [CW-1:0] cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  op_addr_gen #(.AW(AW), .CW(CW)) i_op_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .imm_sz_i(imm_sz), .imm_fix_i(imm_fix), .fld_sz_i(fld_sz),
    .pc_i(pc), .x_i(xr), .y_i(yr),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_data_i(rdata),
    .done_o(done), .addr_o(addr), .pc_o(pc_out), .cycles_o(cycles)
  );

  logic [7:0] mem [logic [63:0]];

  function automatic logic [7:0] rd_byte(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) rdata <= rd_byte(mem_addr);

  function automatic logic [63:0] rd_le(input logic [63:0] a, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v |= 64'(rd_byte(a + 64'(i))) << (8 * i);
    return v;
  endfunction

  task automatic wr_le(input logic [63:0] a, input logic [63:0] v);
    for (int i = 0; i < 8; i++) mem[a + 64'(i)] = v[8*i +: 8];
  endtask

  int checks = 0, errors = 0;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [63:0] q_addr[$], q_pc[$];
  int          q_cyc[$], q_rd[$];
  string       q_tag[$];

  // monitor
  int          rd_cnt = 0;
  logic        prev_rd = 1'b0;
  logic [63:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (prev_rd) check("R6", "read address step", mem_addr, prev_addr + 64'd1);
        rd_cnt++;
      end
      prev_rd = mem_rd;
      prev_addr = mem_addr;
      if (done) begin
        if (q_addr.size() == 0) begin
          check("R11", "unexpected done", 64'd1, 64'd0);
        end else begin
          automatic string t = q_tag.pop_front();
          check(t, "addr", addr, q_addr.pop_front());
          check(t, "pc", pc_out, q_pc.pop_front());
          check(t, "cycles", 64'(cycles), 64'(q_cyc.pop_front()));
          check("R6", {t, " read count"}, 64'(rd_cnt), 64'(q_rd.pop_front()));
        end
        rd_cnt = 0;
      end
    end
  end

  task automatic run(input logic [3:0] m, input logic [1:0] isz, input logic [1:0] ifix,
                     input logic [1:0] fsz, input logic [63:0] p, input logic [63:0] x,
                     input logic [63:0] y, input string tag, input bit poke);
    int n;
    logic [63:0] fld, ea, ep;
    int ec, er;
    n = 1 << fsz;
    fld = rd_le(p, n);
    ep = p + 64'(n);
    case (m)
      M_IMM: begin
        ea = p;
        ep = p + ((ifix == 2'd0) ? (64'd1 << isz) : (ifix == 2'd2) ? 64'd0 : 64'd1);
        ec = 1; er = 0;
      end
      M_ZP, M_ABS: begin ea = fld;     ec = n + 2;  er = n;     end
      M_ZPX:       begin ea = fld + x; ec = n + 3;  er = n;     end
      M_ZPY:       begin ea = fld + y; ec = n + 3;  er = n;     end
      M_IND:       begin ea = rd_le(fld, 8);     ec = n + 11; er = n + 8; end
      M_INDX:      begin ea = rd_le(fld + x, 8); ec = n + 12; er = n + 8; end
      M_INDY:      begin ea = rd_le(fld, 8) + y; ec = n + 12; er = n + 8; end
      default:     begin ea = '0; ep = p; ec = 0; er = 0; end
    endcase
    q_addr.push_back(ea); q_pc.push_back(ep); q_cyc.push_back(ec);
    q_rd.push_back(er); q_tag.push_back(tag);
    @(posedge clk); #1;
    mode = m; imm_sz = isz; imm_fix = ifix; fld_sz = fsz; pc = p; xr = x; yr = y;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      start = 1'b1; mode = M_IMM; pc = 64'hDEAD;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (q_addr.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual no done, expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wr_le(64'h1000, 64'h1122_3344_5566_7788);
    wr_le(64'h2000, 64'h0000_0000_0000_0300);
    wr_le(64'h0300, 64'hDEAD_BEEF_0000_1000);
    wr_le(64'h0310, 64'h0123_4567_89AB_CDEF);
    wr_le(64'h3000, 64'hFFFF_FFFF_FFFF_FFF0);
    wr_le(64'hFFFF_FFFF_FFFF_FFFC, 64'h0);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "mem_rd", 64'(mem_rd), 64'd0);
    check("R1", "addr", addr, 64'd0);
    check("R1", "pc", pc_out, 64'd0);
    check("R1", "cycles", 64'(cycles), 64'd0);

    run(M_IMPL, 2'd3, 2'd0, 2'd3, 64'h1234, 64'd0, 64'd0, "R2", 1'b0);
    run(4'd12,  2'd0, 2'd0, 2'd0, 64'h5678, 64'd0, 64'd0, "R2", 1'b0);

    run(M_IMM, 2'd0, 2'd0, 2'd0, 64'h4000, 64'd0, 64'd0, "R3", 1'b0);
    run(M_IMM, 2'd1, 2'd0, 2'd0, 64'h4000, 64'd0, 64'd0, "R3", 1'b0);
    run(M_IMM, 2'd2, 2'd0, 2'd0, 64'h4000, 64'd0, 64'd0, "R3", 1'b0);
    run(M_IMM, 2'd3, 2'd0, 2'd0, 64'h4000, 64'd0, 64'd0, "R3", 1'b0);
    run(M_IMM, 2'd3, 2'd1, 2'd0, 64'h4000, 64'd0, 64'd0, "R4", 1'b0);
    run(M_IMM, 2'd2, 2'd2, 2'd0, 64'h4000, 64'd0, 64'd0, "R4", 1'b0);
    run(M_IMM, 2'd3, 2'd3, 2'd0, 64'h4000, 64'd0, 64'd0, "R4", 1'b0);

    run(M_ZP,  2'd3, 2'd0, 2'd0, 64'h1000, 64'd0, 64'd0, "R5", 1'b0);
    run(M_ABS, 2'd0, 2'd0, 2'd1, 64'h1000, 64'd0, 64'd0, "R5", 1'b0);
    run(M_ABS, 2'd0, 2'd0, 2'd2, 64'h1000, 64'd0, 64'd0, "R5", 1'b0);
    run(M_ABS, 2'd0, 2'd0, 2'd3, 64'h1000, 64'd0, 64'd0, "R5", 1'b0);

    run(M_ZPX, 2'd0, 2'd0, 2'd1, 64'h1000, 64'h21, 64'h99, "R7", 1'b0);
    run(M_ZPY, 2'd0, 2'd0, 2'd1, 64'h1000, 64'h21, 64'h99, "R7", 1'b0);
    run(M_ZPX, 2'd0, 2'd0, 2'd3, 64'h3000, 64'h20, 64'h0,  "R12", 1'b0);
    run(M_ZPY, 2'd0, 2'd0, 2'd3, 64'h3000, 64'h0,  64'h17, "R12", 1'b0);
    run(M_ABS, 2'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, "R12", 1'b0);

    run(M_IND,  2'd0, 2'd0, 2'd1, 64'h2000, 64'h10, 64'h5, "R8", 1'b0);
    run(M_INDX, 2'd0, 2'd0, 2'd1, 64'h2000, 64'h10, 64'h5, "R9", 1'b0);
    run(M_INDY, 2'd0, 2'd0, 2'd1, 64'h2000, 64'h10, 64'h5, "R10", 1'b0);
    run(M_INDY, 2'd0, 2'd0, 2'd1, 64'h2000, 64'h0, 64'h2111_0000_0000_0000, "R12", 1'b0);

    run(M_ABS, 2'd0, 2'd0, 2'd3, 64'h1000, 64'd0, 64'd0, "R11", 1'b1);
    repeat (4) @(negedge clk);
    check("R11", "stray results pending", 64'(q_addr.size()), 64'd0);
    check("R11", "done idle", 64'(done), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule